// File: doc/BRIEF.md
# Two-Wire Serial Register Target

This block is a target (slave) on a two-wire serial bus of the I2C kind. It answers to one fixed 7-bit device address and holds a small bank of byte-wide registers. Both bus wires are sampled by the fast system clock through two-flop synchronisers. Edges and bus conditions are found on the synchronised copies. The data wire is driven only through an open-drain enable: when `sda_oe` is high, the pad pulls SDA low. When it is low, the line floats high.

A controller writes by sending the device address with the direction bit clear. The first data byte becomes the register index. Each later byte lands at that index, and the index then steps forward. A controller reads by addressing the device with the direction bit set. The target then returns bytes from the current index, one after another, for as long as the controller acknowledges. The index is kept between transfers. A write phase can therefore set it, and a repeated START can follow straight into a read from that location.

Top module: `i2c_reg_target`

## Requirements
- R1: A falling SDA while SCL is high (START or repeated START) puts the target into address reception with its bit count at zero, from any state.
- R2: A rising SDA while SCL is high (STOP) ends the transfer. The target releases SDA and ignores all bus bits until the next START.
- R3: The first byte after a START carries 7 address bits, MSB first, then a direction bit (1 = read, 0 = write). If the address matches `DEV_ADDR`, the target pulls SDA low for the whole ninth clock. Otherwise it leaves SDA released and ignores the rest of the transfer.
- R4: In a write transfer the target pulls SDA low in the ninth clock of every received byte.
- R5: The first data byte of a write transfer sets the register index to that byte modulo `NUM_REGS`. Each later byte is stored at the index, and the index then increases by one.
- R6: In a read transfer the target sends the register at the index, MSB first, and then increases the index by one. It sends the next byte if the controller pulls SDA low in the ninth clock. After a ninth clock with SDA high, it drives nothing until the next START.
- R7: The register index is kept across STOP and repeated START. Only a first write data byte or a byte transfer changes it.
- R8: Stepping past register `NUM_REGS-1` wraps the index to register 0, for both writes and reads.
- R9: A START or STOP in the middle of a byte discards the partial byte. No register or index update results.
- R10: Reset leaves SDA released. The target only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all bus sampling is done on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock wire as seen at the pad |
| sda_i | input | 1 | Bus data wire as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench sets the index in a write phase and then reads across a repeated START. A target that cleared the index on START would return register 0 instead of the stored bytes. It runs writes and reads across the last register, where a missing wrap would reach a register that does not exist. It also sends an index byte above the bank size, which a design without the modulo would store in the wrong place.

A STOP in the middle of a byte, and a START in the middle of a byte, check that a partial byte is discarded rather than written or counted into the next byte. Traffic to a foreign address must leave the registers untouched and SDA released. A NACKed read must be followed by a clock in which the target no longer drives; a design that kept sending would pull the line low there.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_i[g]};
      end
      assign sync_o[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h42,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [1:0] bus_sync;
  logic scl_s, sda_s, scl_d, sda_d;
  logic start_evt, stop_evt, scl_rise, scl_fall;

  i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i({scl_i, sda_i}), .sync_o(bus_sync)
  );
  assign scl_s = bus_sync[1];
  assign sda_s = bus_sync[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, rd_data, wr_data;
  logic [PTR_W-1:0]  ptr, wr_addr;
  logic              rd_dir, first_byte, master_ack, wr_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_load(input logic [BYTE_W-1:0] b);
    return PTR_W'(int'(b) % NUM_REGS);
  endfunction

  i2c_tgt_regfile #(.DEPTH(NUM_REGS), .WIDTH(BYTE_W), .AW(PTR_W)) u_regs (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sda_oe     <= 1'b0;
      rd_dir     <= 1'b0;
      first_byte <= 1'b0;
      master_ack <= 1'b0;
      ptr        <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        if (scl_rise) begin
          case (state)
            ST_ADDR, ST_WR_BYTE:
              if (bit_cnt != FULL) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
              end
            ST_RD_BYTE:
              if (bit_cnt != FULL) bit_cnt <= bit_cnt + 1'b1;
            ST_RD_ACK: master_ack <= ~sda_s;
            default: ;
          endcase
        end
        if (scl_fall) begin
          case (state)
            ST_ADDR:
              if (bit_cnt == FULL) begin
                if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rd_dir <= rx_sh[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end
            ST_ADDR_ACK: begin
              bit_cnt <= '0;
              if (rd_dir) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= ST_RD_BYTE;
              end else begin
                sda_oe     <= 1'b0;
                first_byte <= 1'b1;
                state      <= ST_WR_BYTE;
              end
            end
            ST_WR_BYTE:
              if (bit_cnt == FULL) begin
                sda_oe     <= 1'b1;
                first_byte <= 1'b0;
                state      <= ST_WR_ACK;
                if (first_byte) begin
                  ptr <= ptr_load(rx_sh);
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_sh;
                  ptr     <= ptr_inc(ptr);
                end
              end
            ST_WR_ACK: begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_WR_BYTE;
            end
            ST_RD_BYTE:
              if (bit_cnt == FULL) begin
                sda_oe <= 1'b0;
                ptr    <= ptr_inc(ptr);
                state  <= ST_RD_ACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            ST_RD_ACK:
              if (master_ack) begin
                tx_sh   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_RD_BYTE;
              end else begin
                state   <= ST_IDLE;
              end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             sda_s,
  input logic             sda_oe,
  input tgt_state_e       state,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && $past(sda_s) && !sda_s) |=> (state == ST_ADDR && bit_cnt == '0)); // R1

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s) && !$past(sda_s) && sda_s) |=> (!sda_oe && state == ST_IDLE)); // R2

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R3

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(BYTE_W)); // R9

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> (!scl_s && !$past(scl_s))); // R10
endmodule

bind i2c_reg_target i2c_tgt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
  .sda_oe(sda_oe), .state(state), .bit_cnt(bit_cnt)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int H = 8;
  localparam logic [7:0] AW_ME = 8'h84;  // 0x42 write
  localparam logic [7:0] AR_ME = 8'h85;  // 0x42 read
  localparam logic [7:0] AW_XX = 8'h2E;  // 0x17 write

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_reg_target dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];
  event       obs_ev;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0) begin
        logic [7:0] a;
        a = obs_q.pop_front();
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R6 unexpected byte actual=%02h expected=none", a);
        end else begin
          chk(tag_q.pop_front(), a, exp_q.pop_front());
        end
      end
    end
  end

  task automatic expect_rd(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0;   tick(2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b;  tick(H);
    scl = 1'b1; tick(H / 2);
    seen = sda_bus;
    tick(H / 2);
    scl = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, ack_bit);
  endtask

  task automatic recv_byte(input logic mack);
    logic [7:0] d;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~mack, s);
    obs_q.push_back(d);
    ->obs_ev;
  endtask

  task automatic wr_seq(input string tag, input logic [7:0] idx, input logic [7:0] d0,
                        input logic [7:0] d1, input int n);
    logic a;
    i2c_start();
    send_byte(AW_ME, a); chk({tag, " addr ack"}, 8'(a), 8'h00);
    send_byte(idx, a);   chk("R4 index ack", 8'(a), 8'h00);
    if (n > 0) begin send_byte(d0, a); chk("R4 data ack", 8'(a), 8'h00); end
    if (n > 1) begin send_byte(d1, a); chk("R4 data ack", 8'(a), 8'h00); end
  endtask

  task automatic rd_phase(input int n);
    logic a;
    i2c_start();
    send_byte(AR_ME, a); chk("R3 read addr ack", 8'(a), 8'h00);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
  endtask

  initial begin
    logic a, s;
    tick(5);
    chk("R10 reset release", 8'(sda_oe), 8'h00);
    rst = 1'b0;
    tick(5);
    chk("R10 idle release", 8'(sda_oe), 8'h00);

    // T1: R1 R3 R4 R5 write four bytes from index 2
    i2c_start();
    send_byte(AW_ME, a); chk("R1 R3 match ack", 8'(a), 8'h00);
    send_byte(8'h02, a); chk("R4 index ack", 8'(a), 8'h00);
    send_byte(8'hA1, a); chk("R4 ack", 8'(a), 8'h00);
    send_byte(8'hB2, a); chk("R4 ack", 8'(a), 8'h00);
    send_byte(8'hC3, a); chk("R4 ack", 8'(a), 8'h00);
    send_byte(8'hD4, a); chk("R4 ack", 8'(a), 8'h00);
    i2c_stop();

    // T2: R5 R6 R7 index set then repeated START read
    expect_rd("R5 R7 reg2", 8'hA1);
    expect_rd("R6 reg3", 8'hB2);
    expect_rd("R6 reg4", 8'hC3);
    wr_seq("R7", 8'h02, 8'h00, 8'h00, 0);
    rd_phase(3);
    clk_bit(1'b1, s);
    chk("R6 released after NACK", 8'(s), 8'h01);
    i2c_stop();
    chk("R2 released after STOP", 8'(sda_oe), 8'h00);

    // T3: R7 index kept across STOP
    wr_seq("R7", 8'h04, 8'h00, 8'h00, 0);
    i2c_stop();
    expect_rd("R7 across STOP reg4", 8'hC3);
    expect_rd("R7 across STOP reg5", 8'hD4);
    rd_phase(2);
    i2c_stop();

    // T4: R8 wrap on write and read
    wr_seq("R8", 8'h0F, 8'h11, 8'h22, 2);
    i2c_stop();
    wr_seq("R8", 8'h0F, 8'h00, 8'h00, 0);
    expect_rd("R8 reg15", 8'h11);
    expect_rd("R8 wrapped reg0", 8'h22);
    rd_phase(2);
    i2c_stop();

    // T5: R5 index modulo bank size (0x13 -> 3)
    wr_seq("R5", 8'h13, 8'h99, 8'h00, 1);
    i2c_stop();
    wr_seq("R5", 8'h03, 8'h00, 8'h00, 0);
    expect_rd("R5 modulo index reg3", 8'h99);
    rd_phase(1);
    i2c_stop();

    // T6: R3 foreign address ignored
    i2c_start();
    send_byte(AW_XX, a); chk("R3 foreign NACK", 8'(a), 8'h01);
    send_byte(8'h02, a); chk("R3 foreign ignored", 8'(a), 8'h01);
    send_byte(8'h77, a); chk("R3 foreign ignored", 8'(a), 8'h01);
    i2c_stop();
    wr_seq("R3", 8'h02, 8'h00, 8'h00, 0);
    expect_rd("R3 reg2 untouched", 8'hA1);
    rd_phase(1);
    i2c_stop();

    // T7: R9 STOP mid-byte discards partial byte
    wr_seq("R9", 8'h02, 8'h00, 8'h00, 0);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    i2c_stop();
    expect_rd("R9 no write, index kept", 8'hA1);
    rd_phase(1);
    i2c_stop();

    // T8: R1 R9 repeated START mid-byte restarts address reception
    i2c_start();
    send_byte(AW_ME, a); chk("R1 addr ack", 8'(a), 8'h00);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    expect_rd("R9 R7 reg3 after aborted index", 8'h99);
    rd_phase(1);
    i2c_stop();

    tick(20);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R6 missing bytes actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule